// File: doc/BRIEF.md
# Receive Frame Alignment Padding Inserter

This block sits in a byte-wide receive datapath. It splices a programmable run of zero bytes into the front of every frame, so that a header further into the frame lands on a word boundary once the frame is written to the receive buffer. A pad length of 2, for example, moves an IP header that follows a 14-byte layer-2 header onto a 32-bit boundary.

The input stream carries valid/ready handshaking, start and end markers, and two per-frame sideband flags that are valid on the start byte. `in_cb` marks a frame that begins with a prepended receive control block of `CB_BYTES` bytes. `in_pre` marks a frame whose preamble bytes were kept. When control blocks are enabled and the frame carries one, the padding goes directly after that block. Otherwise it goes ahead of the first byte of the frame, whether that byte is a preamble byte or the first layer-2 header byte. With timestamping on, the pad length is never below eight. The configuration is captured at each frame start and held for the whole frame. While pad bytes are emitted the input is stalled, so no byte is buffered, lost or reordered.

The control is a four-state machine:
- `ST_IDLE` waits for a start byte.
- `ST_HEAD` passes the rest of a control block.
- `ST_PAD` emits zero bytes.
- `ST_BODY` passes bytes until the end marker.

The transitions are:
- IDLE→HEAD: a start byte with a control block is accepted.
- IDLE→PAD: the first of several pad bytes is sent.
- IDLE→BODY: either a single pad byte is sent, or a start byte is passed when no padding is due.
- HEAD→PAD: the last control-block byte is passed and padding is due.
- HEAD→BODY: the last control-block byte is passed and no padding is due.
- HEAD→IDLE: the end byte arrives inside the control block.
- PAD→BODY: the last pad byte is sent.
- BODY→IDLE: the end byte is passed.

Top module: `rx_align_pad`

## Requirements
- R1: After reset, with no input offered, `out_valid` is 0 and `in_ready` is 1.
- R2: With timestamping off, the number of zero bytes inserted per frame equals `cfg_pad_len` (0 to 31). A value of 0 passes the frame unchanged.
- R3: With `cfg_ts_en` = 1, a `cfg_pad_len` below 8 gives exactly 8 pad bytes, and a value of 8 or more gives that many.
- R4: Inserted bytes have data 0x00 and never carry `out_eof`.
- R5: `out_sof` is 1 on exactly the first byte emitted for each frame, which is a pad byte when padding leads the frame, and 0 on every other byte.
- R6: When `cfg_cb_en` = 1 and `in_cb` = 1 on the start byte, the first `CB_BYTES` input bytes pass first, then the padding, then the rest. A frame of `CB_BYTES` bytes or fewer gets no padding.
- R7: If either `cfg_cb_en` or `in_cb` is 0, the padding precedes the first input byte.
- R8: `in_pre` does not move the insertion point. `out_cb` and `out_pre` repeat `in_cb` and `in_pre` on the `out_sof` byte and are 0 on all other bytes.
- R9: Changes to `cfg_pad_len` or `cfg_ts_en` made after a frame's first byte has been transferred do not affect that frame.
- R10: `in_ready` is 0 whenever a pad byte is offered. Every input byte of a frame appears at the output once, in order, and output back-pressure stalls the input.
- R11: In `ST_IDLE`, a valid byte without `in_sof` is accepted and discarded, and nothing is emitted for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_pad_len | input | LEN_W | Programmed pad length in bytes |
| cfg_ts_en | input | 1 | Timestamping on: pad length of at least 8 |
| cfg_cb_en | input | 1 | Control blocks are prepended to frames |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted this cycle |
| in_data | input | DATA_W | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_cb | input | 1 | Frame carries a control block (valid on the start byte) |
| in_pre | input | 1 | Frame kept its preamble (valid on the start byte) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | DATA_W | Output byte |
| out_sof | output | 1 | First emitted byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| out_cb | output | 1 | Control-block flag of the frame, on the start byte |
| out_pre | output | 1 | Preamble flag of the frame, on the start byte |

## Verification
Frames are sent with pad lengths of 0, 1, 2 and 31, and with timestamping set against pad lengths below and above eight. This separates a pass-through frame, a single-pad frame taken straight from idle, a multi-pad run, and the clamp to eight. Frames with a control block are sent longer than, equal to and shorter than the block, and with only one of the two control-block conditions set. These show whether the pad lands after the block and whether a short frame is left unpadded. A configuration write in the middle of a frame, a stray byte that has no start marker, and random output back-pressure show whether the captured setting holds, whether idle bytes are discarded, and whether stalls lose or repeat any input byte.

// File: rtl/rxpad_pkg.sv
package rxpad_pkg;

    // Control states of the padding inserter
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HEAD,
        ST_PAD,
        ST_BODY
    } rxpad_state_e;

    // Source of the output data byte
    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_IN,
        SRC_ZERO
    } rxpad_src_e;

endpackage

// File: rtl/rxpad_cfg_snap.sv
module rxpad_cfg_snap #(
    parameter int LEN_W  = 5,
    parameter int TS_MIN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [LEN_W-1:0] cfg_pad_len,
    input  logic             cfg_ts_en,
    output logic [LEN_W-1:0] eff_now,
    output logic [LEN_W-1:0] eff_held
);

    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(TS_MIN);

    // Timestamping raises a short pad to the minimum
    always_comb begin
        if (cfg_ts_en && (cfg_pad_len < MIN_LEN)) begin
            eff_now = MIN_LEN;
        end else begin
            eff_now = cfg_pad_len;
        end
    end

    // Tracks the live value while idle; frozen once a frame has begun
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eff_held <= '0;
        end else if (capture) begin
            eff_held <= eff_now;
        end
    end

endmodule

// File: rtl/rxpad_cnt.sv
module rxpad_cnt #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign last = (cnt == CNT_W'(1));

endmodule

// File: rtl/rxpad_ctrl.sv
module rxpad_ctrl
    import rxpad_pkg::*;
#(
    parameter int LEN_W  = 5,
    parameter int CNT_W  = 6,
    parameter int CB_LEN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic             in_cb,
    input  logic             cfg_cb_en,
    input  logic             out_ready,
    input  logic [LEN_W-1:0] eff_now,
    input  logic [LEN_W-1:0] eff_held,
    input  logic             cnt_last,
    output logic             in_ready,
    output logic             out_valid,
    output logic             out_sof,
    output rxpad_src_e       src,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             cnt_dec,
    output logic             capture,
    output rxpad_state_e     state
);

    rxpad_state_e nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next state and outputs
    always_comb begin
        nxt       = state;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_sof   = 1'b0;
        src       = SRC_NONE;
        cnt_load  = 1'b0;
        cnt_val   = '0;
        cnt_dec   = 1'b0;
        capture   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                capture = 1'b1;
                if (in_valid && in_sof) begin
                    if (cfg_cb_en && in_cb) begin
                        // control block leads: pass its first byte
                        src       = SRC_IN;
                        out_valid = 1'b1;
                        out_sof   = 1'b1;
                        in_ready  = out_ready;
                        if (out_ready && !in_eof) begin
                            if (CB_LEN == 1) begin
                                if (eff_now != '0) begin
                                    nxt      = ST_PAD;
                                    cnt_load = 1'b1;
                                    cnt_val  = CNT_W'(eff_now);
                                end else begin
                                    nxt = ST_BODY;
                                end
                            end else begin
                                nxt      = ST_HEAD;
                                cnt_load = 1'b1;
                                cnt_val  = CNT_W'(CB_LEN - 1);
                            end
                        end
                    end else if (eff_now != '0) begin
                        // padding leads: first pad byte, input held
                        src       = SRC_ZERO;
                        out_valid = 1'b1;
                        out_sof   = 1'b1;
                        in_ready  = 1'b0;
                        if (out_ready) begin
                            if (eff_now == LEN_W'(1)) begin
                                nxt = ST_BODY;
                            end else begin
                                nxt      = ST_PAD;
                                cnt_load = 1'b1;
                                cnt_val  = CNT_W'(eff_now) - CNT_W'(1);
                            end
                        end
                    end else begin
                        // no padding due: plain pass-through
                        src       = SRC_IN;
                        out_valid = 1'b1;
                        out_sof   = 1'b1;
                        in_ready  = out_ready;
                        if (out_ready && !in_eof) begin
                            nxt = ST_BODY;
                        end
                    end
                end else begin
                    // stray byte outside a frame: accept and drop
                    in_ready = 1'b1;
                end
            end
            ST_HEAD: begin
                src       = SRC_IN;
                out_valid = in_valid;
                in_ready  = out_ready;
                if (in_valid && out_ready) begin
                    if (in_eof) begin
                        nxt = ST_IDLE;
                    end else if (cnt_last) begin
                        if (eff_held != '0) begin
                            nxt      = ST_PAD;
                            cnt_load = 1'b1;
                            cnt_val  = CNT_W'(eff_held);
                        end else begin
                            nxt = ST_BODY;
                        end
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
            end
            ST_PAD: begin
                src       = SRC_ZERO;
                out_valid = 1'b1;
                in_ready  = 1'b0;
                if (out_ready) begin
                    if (cnt_last) begin
                        nxt = ST_BODY;
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
            end
            ST_BODY: begin
                src       = SRC_IN;
                out_valid = in_valid;
                in_ready  = out_ready;
                if (in_valid && out_ready && in_eof) begin
                    nxt = ST_IDLE;
                end
            end
        endcase
    end

endmodule

// File: rtl/rx_align_pad.sv
module rx_align_pad
    import rxpad_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int LEN_W    = 5,
    parameter int TS_MIN   = 8,
    parameter int CB_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_pad_len,
    input  logic              cfg_ts_en,
    input  logic              cfg_cb_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_cb,
    input  logic              in_pre,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_cb,
    output logic              out_pre
);

    localparam int PAD_MAX = (1 << LEN_W) - 1;
    localparam int CNT_MAX = (CB_BYTES > PAD_MAX) ? CB_BYTES : PAD_MAX;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [LEN_W-1:0] eff_now;
    logic [LEN_W-1:0] eff_held;
    logic             capture;
    logic             cnt_load;
    logic             cnt_dec;
    logic             cnt_last;
    logic [CNT_W-1:0] cnt_val;
    rxpad_src_e       src;
    rxpad_state_e     state;

    rxpad_cfg_snap #(
        .LEN_W (LEN_W),
        .TS_MIN(TS_MIN)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .cfg_pad_len(cfg_pad_len),
        .cfg_ts_en  (cfg_ts_en),
        .eff_now    (eff_now),
        .eff_held   (eff_held)
    );

    rxpad_cnt #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_val),
        .dec     (cnt_dec),
        .last    (cnt_last)
    );

    rxpad_ctrl #(
        .LEN_W (LEN_W),
        .CNT_W (CNT_W),
        .CB_LEN(CB_BYTES)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_eof   (in_eof),
        .in_cb    (in_cb),
        .cfg_cb_en(cfg_cb_en),
        .out_ready(out_ready),
        .eff_now  (eff_now),
        .eff_held (eff_held),
        .cnt_last (cnt_last),
        .in_ready (in_ready),
        .out_valid(out_valid),
        .out_sof  (out_sof),
        .src      (src),
        .cnt_load (cnt_load),
        .cnt_val  (cnt_val),
        .cnt_dec  (cnt_dec),
        .capture  (capture),
        .state    (state)
    );

    // Output data path: zero for padding, input byte otherwise
    always_comb begin
        out_data = '0;
        out_eof  = 1'b0;
        if (src == SRC_IN) begin
            out_data = in_data;
            out_eof  = in_eof;
        end
    end

    assign out_cb  = out_sof & in_cb;
    assign out_pre = out_sof & in_pre;

    // ---------------- assertions ----------------
    logic pad_xfer;
    logic real_xfer;
    logic frame_first;
    logic [LEN_W:0] pad_run;

    assign pad_xfer  = out_valid && out_ready && !in_ready;
    assign real_xfer = out_valid && out_ready && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_first <= 1'b1;
            pad_run     <= '0;
        end else begin
            if (out_valid && out_ready) begin
                frame_first <= out_eof;
            end
            if (pad_xfer) begin
                pad_run <= pad_run + 1'b1;
            end else if (real_xfer) begin
                pad_run <= '0;
            end
        end
    end

    // R4: inserted bytes are zero and never end a frame
    assert_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pad_xfer |-> (out_data == '0) && !out_eof);

    // R5: start marker on the first emitted byte of a frame only
    assert_sof_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && frame_first) |-> out_sof);

    assert_sof_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !frame_first) |-> !out_sof);

    // R2 / R3: a run of pad bytes matches the length captured for the frame
    assert_pad_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (real_xfer && (pad_run != '0)) |-> (pad_run == {1'b0, eff_held}));

    // R10: an accepted input byte of a frame is emitted in the same cycle
    assert_no_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && ((state != ST_IDLE) || in_sof)) |-> (out_valid && out_ready));

endmodule

// File: tb/test_rx_align_pad.sv
module test_rx_align_pad;

    localparam int DATA_W = 8;
    localparam int LEN_W  = 5;
    localparam int CB_N   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [LEN_W-1:0]  cfg_pad_len = '0;
    logic              cfg_ts_en = 1'b0;
    logic              cfg_cb_en = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_sof = 1'b0;
    logic              in_eof = 1'b0;
    logic              in_cb = 1'b0;
    logic              in_pre = 1'b0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [DATA_W-1:0] out_data;
    logic              out_sof;
    logic              out_eof;
    logic              out_cb;
    logic              out_pre;

    always #10 clk = ~clk;

    rx_align_pad #(
        .DATA_W  (DATA_W),
        .LEN_W   (LEN_W),
        .TS_MIN  (8),
        .CB_BYTES(CB_N)
    ) i_rx_align_pad (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_pad_len(cfg_pad_len),
        .cfg_ts_en  (cfg_ts_en),
        .cfg_cb_en  (cfg_cb_en),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .in_sof     (in_sof),
        .in_eof     (in_eof),
        .in_cb      (in_cb),
        .in_pre     (in_pre),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_sof    (out_sof),
        .out_eof    (out_eof),
        .out_cb     (out_cb),
        .out_pre    (out_pre)
    );

    typedef struct {
        logic [7:0] d;
        logic       s;
        logic       e;
        logic       c;
        logic       p;
        string      tag;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R1";
    bit    bp_en = 1'b0;
    int    byte_seq = 0;
    bit    done = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input bit s, input bit e,
                        input bit c, input bit p);
        item_t it;
        it.d = d; it.s = s; it.e = e; it.c = c; it.p = p; it.tag = cur_tag;
        exp_q.push_back(it);
    endtask

    // Driver: builds the expected output from the requirements, then drives the frame
    task automatic send_frame(input int len, input bit cb, input bit pre, input int new_pad);
        int eff;
        bit cba;
        bit first;
        logic [7:0] bytes[$];
        eff   = (cfg_ts_en && cfg_pad_len < 8) ? 8 : int'(cfg_pad_len);
        cba   = cfg_cb_en && cb;
        first = 1'b1;
        for (int i = 0; i < len; i++) begin
            bytes.push_back(8'((byte_seq % 255) + 1));
            byte_seq++;
        end
        if (!cba) begin
            for (int k = 0; k < eff; k++) begin
                push(8'h00, first, 1'b0, first & cb, first & pre);
                first = 1'b0;
            end
        end
        for (int i = 0; i < len; i++) begin
            if (cba && i == CB_N) begin
                for (int k = 0; k < eff; k++) push(8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
            end
            push(bytes[i], first, i == len - 1, first & cb, first & pre);
            first = 1'b0;
        end
        for (int i = 0; i < len; i++) begin
            bit acc;
            in_valid = 1'b1;
            in_data  = bytes[i];
            in_sof   = (i == 0);
            in_eof   = (i == len - 1);
            in_cb    = cb;
            in_pre   = pre;
            do begin
                #2 acc = in_ready;
                @(negedge clk);
            end while (!acc);
            if (i == 0 && new_pad >= 0) cfg_pad_len = LEN_W'(new_pad);
        end
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
    endtask

    // Back-pressure generator
    always @(negedge clk) begin
        #1 out_ready = bp_en ? (($urandom % 4) != 0) : 1'b1;
    end

    // Monitor: pops the scoreboard on every output transfer
    always @(negedge clk) begin
        #3;
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10/R11", "unexpected output byte", int'(out_data), 0);
            end else begin
                item_t ex;
                ex = exp_q.pop_front();
                check({out_data, out_sof, out_eof, out_cb, out_pre} ==
                      {ex.d, ex.s, ex.e, ex.c, ex.p}, ex.tag,
                      "byte{data,sof,eof,cb,pre}",
                      int'({out_data, out_sof, out_eof, out_cb, out_pre}),
                      int'({ex.d, ex.s, ex.e, ex.c, ex.p}));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        @(negedge clk);

        // R2: pad lengths 2, 0, 1, 31
        cur_tag = "R2"; cfg_pad_len = 5'd2;  send_frame(6, 1'b0, 1'b0, -1);
        cur_tag = "R2"; cfg_pad_len = 5'd0;  send_frame(4, 1'b0, 1'b0, -1);
        cur_tag = "R5"; cfg_pad_len = 5'd1;  send_frame(1, 1'b0, 1'b0, -1);
        cur_tag = "R2"; cfg_pad_len = 5'd31; send_frame(3, 1'b0, 1'b0, -1);

        // R3: timestamp clamp
        cfg_ts_en = 1'b1;
        cur_tag = "R3"; cfg_pad_len = 5'd3;  send_frame(5, 1'b0, 1'b0, -1);
        cur_tag = "R3"; cfg_pad_len = 5'd0;  send_frame(2, 1'b0, 1'b0, -1);
        cur_tag = "R3"; cfg_pad_len = 5'd12; send_frame(4, 1'b0, 1'b0, -1);
        cfg_ts_en = 1'b0;

        // R6: control block before padding
        cfg_cb_en = 1'b1;
        cur_tag = "R6"; cfg_pad_len = 5'd4; send_frame(12, 1'b1, 1'b0, -1);
        cur_tag = "R6"; send_frame(5, 1'b1, 1'b0, -1);
        cur_tag = "R6"; send_frame(CB_N, 1'b1, 1'b0, -1);
        cur_tag = "R6"; send_frame(CB_N + 1, 1'b1, 1'b1, -1);

        // R7: only one of the two control-block conditions
        cur_tag = "R7"; send_frame(10, 1'b0, 1'b0, -1);
        cfg_cb_en = 1'b0;
        cur_tag = "R7"; send_frame(10, 1'b1, 1'b0, -1);

        // R8: preamble flag keeps insertion point
        cur_tag = "R8"; cfg_pad_len = 5'd2; send_frame(7, 1'b0, 1'b1, -1);

        // R9: mid-frame configuration change ignored
        cfg_cb_en = 1'b1;
        cur_tag = "R9"; cfg_pad_len = 5'd3; send_frame(11, 1'b1, 1'b0, 9);
        cur_tag = "R9"; send_frame(11, 1'b1, 1'b0, -1);

        // R11: stray byte in idle
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b0; in_data = 8'hA5;
        #2;
        check(out_valid == 1'b0, "R11", "out_valid on stray byte", int'(out_valid), 0);
        check(in_ready == 1'b1, "R11", "in_ready on stray byte", int'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        cur_tag = "R11"; cfg_cb_en = 1'b0; cfg_pad_len = 5'd2; send_frame(3, 1'b0, 1'b0, -1);

        // R10: random back-pressure across the modes
        bp_en = 1'b1;
        cur_tag = "R10"; cfg_pad_len = 5'd5; send_frame(9, 1'b0, 1'b1, -1);
        cfg_cb_en = 1'b1;
        cur_tag = "R10"; send_frame(14, 1'b1, 1'b0, -1);
        cfg_ts_en = 1'b1;
        cur_tag = "R10"; cfg_pad_len = 5'd1; send_frame(13, 1'b1, 1'b1, -1);
        cur_tag = "R10"; cfg_pad_len = 5'd6; send_frame(3, 1'b0, 1'b0, -1);
        cfg_ts_en = 1'b0;
        cur_tag = "R10"; cfg_pad_len = 5'd0; send_frame(9, 1'b1, 1'b0, -1);

        repeat (100) begin
            if (exp_q.size() != 0) @(negedge clk);
        end
        bp_en = 1'b0;
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R10", "scoreboard left over", exp_q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule